// File: doc/BRIEF.md
# Pending Task Store with Join Counters

This block keeps successor tasks that cannot run yet because some of their input values are missing. A requester asks for a new pending entry by giving the successor's task type, the continuation that the successor itself must eventually return to, and how many values it still waits for. The store takes a free entry, loads that number into the entry's join counter, and answers one cycle later with a continuation that names this tile, the entry and slot zero. The requester sets the slot field to the slot it wants before it hands the continuation to a child task.

Children return results as argument messages carrying a continuation, a data word and the number of the processing element that produced it. The store writes the word into the addressed slot and counts the entry's join counter down. When the count reaches zero, the complete task appears on a registered output with a valid/ready handshake: its type, its parent continuation and every argument. It is steered to the processing element that delivered the final value, and the entry goes back to the free pool in the same cycle. Messages that address nothing live are dropped and set a sticky error flag.

Top module: `pts_store`

## Requirements
- R1: After reset no entry is in use, `create_ready` is 1, and `rsp_valid`, `task_valid` and `err_flag` are 0.
- R2: An accepted create request takes the lowest-numbered free entry. In the next cycle `rsp_valid` is 1 and `rsp_cont` is {TILE_ID, entry index, slot 0}. The continuation layout, from the most significant end, is tile field (TILE_W bits), entry index, and slot in the least significant bits.
- R3: While every entry is in use, `create_ready` is 0 and a presented create produces no response.
- R4: An accepted argument to a live entry stores its data in the addressed slot and decrements the join counter. While the counter stays above zero, no task is emitted.
- R5: The cycle after the argument that brings the counter to zero is accepted, `task_valid` is 1. `task_type` and `task_cont` hold the values given at creation, slot i sits at `task_args[i*DATA_W +: DATA_W]`, and `task_dest` equals that argument's `arg_src_pe`.
- R6: The completing entry is released in the same cycle and can be allocated again by a later create.
- R7: While `task_valid` is 1 and `task_ready` is 0, `arg_ready` is 0 and all task outputs hold. When `task_ready` is 1, a waiting argument can be accepted in the same cycle the old task leaves.
- R8: An argument whose tile field differs from TILE_ID, whose entry is not in use, or whose slot is NUM_ARGS or more is dropped and sets `err_flag`, which stays set until reset. The target entry's counter and slots are not changed.
- R9: Arguments may arrive in any slot order. The emitted task carries each value in its own slot regardless of arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| create_valid | input | 1 | Create request present |
| create_ready | output | 1 | A free entry exists |
| create_type | input | TYPE_W | Successor task type |
| create_cont | input | CONT_W | Continuation of the successor itself |
| create_count | input | CNT_W | Missing argument count, 1 to NUM_ARGS |
| rsp_valid | output | 1 | Continuation response valid for one cycle |
| rsp_cont | output | CONT_W | Continuation pointing at slot 0 of the new entry |
| arg_valid | input | 1 | Argument message present |
| arg_ready | output | 1 | Argument can be taken this cycle |
| arg_cont | input | CONT_W | Target tile, entry and slot |
| arg_data | input | DATA_W | Returned value |
| arg_src_pe | input | PE_W | Producer of the value |
| task_valid | output | 1 | Ready task on output |
| task_ready | input | 1 | Consumer takes the task |
| task_type | output | TYPE_W | Type of ready task |
| task_cont | output | CONT_W | Parent continuation of ready task |
| task_args | output | NUM_ARGS*DATA_W | All arguments, slot 0 lowest |
| task_dest | output | PE_W | Processing element that receives the task |
| err_flag | output | 1 | Sticky bad-address indication |

## Verification
The bench builds the store with four entries, three argument slots, 8-bit data and tile number 1. Four entries let a short sequence fill the pool, observe the stall, and watch a freed index come back as the lowest free one. Three slots in a 2-bit slot field leave code 3 unused, which makes the out-of-range slot drop reachable next to the wrong-tile and dead-entry cases. Three slots also give enough arguments to deliver them out of order.

// File: rtl/pts_pkg.sv
package pts_pkg;
   // Width of an index field able to name n items; never below one bit.
   function automatic int unsigned field_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // Width of a counter able to hold the value n.
   function automatic int unsigned count_bits(input int unsigned n);
      return $clog2(n + 1);
   endfunction
endpackage

// File: rtl/pts_free_list.sv
module pts_free_list #(
   parameter int unsigned N     = 8,
   parameter int unsigned IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_en,
   input  logic             free_en,
   input  logic [IDX_W-1:0] free_idx,
   output logic             has_free,
   output logic [IDX_W-1:0] alloc_idx,
   output logic [N-1:0]     live
);
   logic [N-1:0] live_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_q <= '0;
      end else begin
         for (int e = 0; e < N; e++) begin
            if (alloc_en && (alloc_idx == IDX_W'(e)))
               live_q[e] <= 1'b1;
            else if (free_en && (free_idx == IDX_W'(e)))
               live_q[e] <= 1'b0;
         end
      end
   end

   // lowest free index wins
   always_comb begin
      has_free  = 1'b0;
      alloc_idx = '0;
      for (int e = N - 1; e >= 0; e--) begin
         if (!live_q[e]) begin
            has_free  = 1'b1;
            alloc_idx = IDX_W'(e);
         end
      end
   end

   assign live = live_q;

   AST_ALLOC_BECOMES_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |=> live_q[$past(alloc_idx)]); // R2
   AST_FREE_ONLY_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      free_en |-> live_q[free_idx]); // R6
endmodule

// File: rtl/pts_join_ctr.sv
module pts_join_ctr #(
   parameter int unsigned N     = 8,
   parameter int unsigned IDX_W = 3,
   parameter int unsigned CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_en,
   input  logic [IDX_W-1:0] load_idx,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec_en,
   input  logic [IDX_W-1:0] dec_idx,
   output logic [CNT_W-1:0] dec_cnt
);
   logic [N-1:0][CNT_W-1:0] cnt_q;

   for (genvar e = 0; e < N; e++) begin : g_ctr
      always_ff @(posedge clk) begin
         if (!rst_n)
            cnt_q[e] <= '0;
         else if (load_en && (load_idx == IDX_W'(e)))
            cnt_q[e] <= load_val;
         else if (dec_en && (dec_idx == IDX_W'(e)))
            cnt_q[e] <= cnt_q[e] - 1'b1;
      end
   end

   assign dec_cnt = cnt_q[dec_idx];

   AST_DEC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      dec_en |-> (dec_cnt != '0)); // R4
endmodule

// File: rtl/pts_arg_bank.sv
module pts_arg_bank #(
   parameter int unsigned N      = 8,
   parameter int unsigned A      = 2,
   parameter int unsigned IDX_W  = 3,
   parameter int unsigned SLOT_W = 1,
   parameter int unsigned DATA_W = 16
) (
   input  logic                clk,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic [SLOT_W-1:0]   wr_slot,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [IDX_W-1:0]    rd_idx,
   output logic [A*DATA_W-1:0] rd_args
);
   localparam int unsigned DEPTH = N * A;

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en)
         mem_q[int'(wr_idx) * A + int'(wr_slot)] <= wr_data;
   end

   // read with bypass of the word written in this cycle
   for (genvar s = 0; s < A; s++) begin : g_slot
      assign rd_args[s*DATA_W +: DATA_W] =
         (wr_en && (wr_idx == rd_idx) && (wr_slot == SLOT_W'(s))) ? wr_data
                                                                  : mem_q[int'(rd_idx) * A + s];
   end
endmodule

// File: rtl/pts_store.sv
module pts_store #(
   parameter int unsigned TILE_ID     = 0,
   parameter int unsigned TILE_W      = 2,
   parameter int unsigned NUM_ENTRIES = 8,
   parameter int unsigned NUM_ARGS    = 2,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned TYPE_W      = 4,
   parameter int unsigned PE_W        = 2,
   localparam int unsigned IDX_W  = pts_pkg::field_bits(NUM_ENTRIES),
   localparam int unsigned SLOT_W = pts_pkg::field_bits(NUM_ARGS),
   localparam int unsigned CNT_W  = pts_pkg::count_bits(NUM_ARGS),
   localparam int unsigned CONT_W = TILE_W + IDX_W + SLOT_W,
   localparam int unsigned ARGS_W = NUM_ARGS * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              create_valid,
   output logic              create_ready,
   input  logic [TYPE_W-1:0] create_type,
   input  logic [CONT_W-1:0] create_cont,
   input  logic [CNT_W-1:0]  create_count,
   output logic              rsp_valid,
   output logic [CONT_W-1:0] rsp_cont,
   input  logic              arg_valid,
   output logic              arg_ready,
   input  logic [CONT_W-1:0] arg_cont,
   input  logic [DATA_W-1:0] arg_data,
   input  logic [PE_W-1:0]   arg_src_pe,
   output logic              task_valid,
   input  logic              task_ready,
   output logic [TYPE_W-1:0] task_type,
   output logic [CONT_W-1:0] task_cont,
   output logic [ARGS_W-1:0] task_args,
   output logic [PE_W-1:0]   task_dest,
   output logic              err_flag
);
   // elaboration-time parameter checks
   if (NUM_ENTRIES < 2) begin : g_bad_entries
      $error("pts_store: NUM_ENTRIES must be at least 2");
   end
   if (NUM_ARGS < 1) begin : g_bad_args
      $error("pts_store: NUM_ARGS must be at least 1");
   end
   if (TILE_ID >= (1 << TILE_W)) begin : g_bad_tile
      $error("pts_store: TILE_ID does not fit in TILE_W");
   end

   localparam logic [TILE_W-1:0] MY_TILE = TILE_W'(TILE_ID);

   // argument address decode
   logic [TILE_W-1:0] a_tile;
   logic [IDX_W-1:0]  a_idx;
   logic [SLOT_W-1:0] a_slot;
   assign a_tile = arg_cont[CONT_W-1 -: TILE_W];
   assign a_idx  = arg_cont[SLOT_W +: IDX_W];
   assign a_slot = arg_cont[SLOT_W-1:0];

   logic [NUM_ENTRIES-1:0] live;
   logic                   has_free;
   logic [IDX_W-1:0]       alloc_idx;
   logic [CNT_W-1:0]       dec_cnt;
   logic [ARGS_W-1:0]      merged_args;

   logic addr_ok, arg_fire, arg_take, arg_last, create_fire;
   logic task_valid_q;

   always_comb begin
      addr_ok = (a_tile == MY_TILE)
             && (int'(a_idx) < NUM_ENTRIES)
             && (int'(a_slot) < NUM_ARGS);
      if (addr_ok)
         addr_ok = live[a_idx];
   end

   assign arg_ready   = !task_valid_q || task_ready;
   assign arg_fire    = arg_valid && arg_ready;
   assign arg_take    = arg_fire && addr_ok;
   assign arg_last    = arg_take && (dec_cnt == CNT_W'(1));
   assign create_ready = has_free;
   assign create_fire  = create_valid && has_free;

   pts_free_list #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_free (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_en  (create_fire),
      .free_en   (arg_last),
      .free_idx  (a_idx),
      .has_free  (has_free),
      .alloc_idx (alloc_idx),
      .live      (live)
   );

   pts_join_ctr #(.N(NUM_ENTRIES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_join (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (create_fire),
      .load_idx (alloc_idx),
      .load_val (create_count),
      .dec_en   (arg_take),
      .dec_idx  (a_idx),
      .dec_cnt  (dec_cnt)
   );

   pts_arg_bank #(.N(NUM_ENTRIES), .A(NUM_ARGS), .IDX_W(IDX_W),
                  .SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_args (
      .clk     (clk),
      .wr_en   (arg_take),
      .wr_idx  (a_idx),
      .wr_slot (a_slot),
      .wr_data (arg_data),
      .rd_idx  (a_idx),
      .rd_args (merged_args)
   );

   // metadata array: task type and parent continuation
   logic [TYPE_W-1:0] meta_type_q [NUM_ENTRIES];
   logic [CONT_W-1:0] meta_cont_q [NUM_ENTRIES];

   always_ff @(posedge clk) begin
      if (create_fire) begin
         meta_type_q[alloc_idx] <= create_type;
         meta_cont_q[alloc_idx] <= create_cont;
      end
   end

   // continuation response
   logic              rsp_valid_q;
   logic [CONT_W-1:0] rsp_cont_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid_q <= 1'b0;
         rsp_cont_q  <= '0;
      end else begin
         rsp_valid_q <= create_fire;
         if (create_fire)
            rsp_cont_q <= {MY_TILE, alloc_idx, {SLOT_W{1'b0}}};
      end
   end

   // ready-task output register
   logic [TYPE_W-1:0] task_type_q;
   logic [CONT_W-1:0] task_cont_q;
   logic [ARGS_W-1:0] task_args_q;
   logic [PE_W-1:0]   task_dest_q;
   logic              err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         task_valid_q <= 1'b0;
         task_type_q  <= '0;
         task_cont_q  <= '0;
         task_args_q  <= '0;
         task_dest_q  <= '0;
         err_q        <= 1'b0;
      end else begin
         if (arg_last) begin
            task_valid_q <= 1'b1;
            task_type_q  <= meta_type_q[a_idx];
            task_cont_q  <= meta_cont_q[a_idx];
            task_args_q  <= merged_args;
            task_dest_q  <= arg_src_pe;
         end else if (task_ready) begin
            task_valid_q <= 1'b0;
         end
         if (arg_fire && !addr_ok)
            err_q <= 1'b1;
      end
   end

   assign rsp_valid  = rsp_valid_q;
   assign rsp_cont   = rsp_cont_q;
   assign task_valid = task_valid_q;
   assign task_type  = task_type_q;
   assign task_cont  = task_cont_q;
   assign task_args  = task_args_q;
   assign task_dest  = task_dest_q;
   assign err_flag   = err_q;

   AST_RSP_FOLLOWS_CREATE: assert property (@(posedge clk) disable iff (!rst_n)
      (create_valid && create_ready) |=> rsp_valid); // R2
   AST_FULL_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      (&live) |=> !rsp_valid); // R3
   AST_TASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (task_valid && !task_ready) |=> (task_valid && $stable(task_args)
                                       && $stable(task_dest) && $stable(task_type))); // R7
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag); // R8
endmodule

// File: tb/tb_pts_store.sv
module tb_pts_store;
   localparam int unsigned NE = 4, NA = 3, DW = 8, TW = 4, PW = 2, TLW = 2;
   localparam int unsigned CW = 6, CNW = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   always #5 clk = ~clk;

   logic create_valid = 0, create_ready;
   logic [TW-1:0] create_type = '0;
   logic [CW-1:0] create_cont = '0;
   logic [CNW-1:0] create_count = '0;
   logic rsp_valid;
   logic [CW-1:0] rsp_cont;
   logic arg_valid = 0, arg_ready;
   logic [CW-1:0] arg_cont = '0;
   logic [DW-1:0] arg_data = '0;
   logic [PW-1:0] arg_src_pe = '0;
   logic task_valid, task_ready = 1'b1;
   logic [TW-1:0] task_type;
   logic [CW-1:0] task_cont;
   logic [NA*DW-1:0] task_args;
   logic [PW-1:0] task_dest;
   logic err_flag;

   int n_tests = 0, n_fail = 0;

   pts_store #(.TILE_ID(1), .TILE_W(TLW), .NUM_ENTRIES(NE), .NUM_ARGS(NA),
               .DATA_W(DW), .TYPE_W(TW), .PE_W(PW)) dut (
      .clk(clk), .rst_n(rst_n),
      .create_valid(create_valid), .create_ready(create_ready),
      .create_type(create_type), .create_cont(create_cont), .create_count(create_count),
      .rsp_valid(rsp_valid), .rsp_cont(rsp_cont),
      .arg_valid(arg_valid), .arg_ready(arg_ready), .arg_cont(arg_cont),
      .arg_data(arg_data), .arg_src_pe(arg_src_pe),
      .task_valid(task_valid), .task_ready(task_ready),
      .task_type(task_type), .task_cont(task_cont), .task_args(task_args),
      .task_dest(task_dest), .err_flag(err_flag)
   );

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [CW-1:0] cont(input int t, input int i, input int s);
      return {2'(t), 2'(i), 2'(s)};
   endfunction

   // one create; response sampled at the negedge after the accepting edge
   task automatic do_create(input int typ, input int pc, input int cnt, input int exp_idx);
      @(negedge clk);
      create_valid = 1; create_type = TW'(typ); create_cont = CW'(pc); create_count = CNW'(cnt);
      check("R3", "create_ready with free entry", 64'(create_ready), 1);
      @(posedge clk);
      @(negedge clk);
      create_valid = 0;
      check("R2", "rsp_valid", 64'(rsp_valid), 1);
      check("R2", "rsp_cont", 64'(rsp_cont), 64'(cont(1, exp_idx, 0)));
   endtask

   task automatic send_arg(input logic [CW-1:0] c, input int d, input int src);
      @(negedge clk);
      arg_valid = 1; arg_cont = c; arg_data = DW'(d); arg_src_pe = PW'(src);
      @(posedge clk);
      @(negedge clk);
      arg_valid = 0;
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R1", "task_valid", 64'(task_valid), 0);
      check("R1", "err_flag", 64'(err_flag), 0);
      check("R1", "create_ready", 64'(create_ready), 1);
      check("R1", "rsp_valid", 64'(rsp_valid), 0);
   endtask

   task automatic t_single;
      do_create(3, 6'h2A, 3, 0);   // A: idx0, 3 args
      do_create(4, 6'h15, 2, 1);   // B: idx1, 2 args
      do_create(9, 6'h3C, 1, 2);   // C: idx2, 1 arg
      send_arg(cont(1, 2, 0), 8'hC0, 2);
      check("R5", "single task_valid", 64'(task_valid), 1);
      check("R5", "single type", 64'(task_type), 9);
      check("R5", "single parent cont", 64'(task_cont), 64'h3C);
      check("R5", "single slot0", 64'(task_args[7:0]), 64'hC0);
      check("R5", "single dest", 64'(task_dest), 2);
      @(negedge clk);
      check("R5", "task drained", 64'(task_valid), 0);
   endtask

   task automatic t_order;
      send_arg(cont(1, 0, 2), 8'hA2, 0);
      check("R4", "no task after 1 of 3", 64'(task_valid), 0);
      send_arg(cont(1, 0, 0), 8'hA0, 1);
      check("R4", "no task after 2 of 3", 64'(task_valid), 0);
      send_arg(cont(1, 0, 1), 8'hA1, 3);
      check("R9", "out-of-order args", 64'(task_args), 64'hA2A1A0);
      check("R9", "order type", 64'(task_type), 3);
      check("R5", "order dest from last", 64'(task_dest), 3);
      @(negedge clk);
   endtask

   task automatic t_full;
      do_create(5, 6'h01, 1, 0);   // R6: freed idx0 reused first
      do_create(6, 6'h02, 2, 2);
      do_create(7, 6'h03, 1, 3);
      @(negedge clk);
      create_valid = 1;
      check("R3", "create_ready when full", 64'(create_ready), 0);
      @(posedge clk);
      @(negedge clk);
      create_valid = 0;
      check("R3", "no response when full", 64'(rsp_valid), 0);
   endtask

   task automatic t_stall;
      task_ready = 0;
      send_arg(cont(1, 1, 0), 8'h11, 1);
      send_arg(cont(1, 1, 1), 8'h22, 3);
      check("R5", "B task valid", 64'(task_valid), 1);
      check("R5", "B args", 64'(task_args[15:0]), 64'h2211);
      arg_valid = 1; arg_cont = cont(1, 0, 0); arg_data = 8'h55; arg_src_pe = 0;
      for (int i = 0; i < 2; i++) begin
         @(negedge clk);
         check("R7", "arg_ready while blocked", 64'(arg_ready), 0);
         check("R7", "held args", 64'(task_args[15:0]), 64'h2211);
         check("R7", "held dest", 64'(task_dest), 3);
      end
      task_ready = 1;
      @(posedge clk);
      @(negedge clk);
      arg_valid = 0;
      check("R7", "back-to-back task valid", 64'(task_valid), 1);
      check("R7", "new task type", 64'(task_type), 5);
      check("R7", "new task slot0", 64'(task_args[7:0]), 64'h55);
      check("R7", "new task dest", 64'(task_dest), 0);
      @(negedge clk);
      check("R7", "drained", 64'(task_valid), 0);
   endtask

   task automatic t_errors;
      check("R8", "err before bad arg", 64'(err_flag), 0);
      send_arg(cont(2, 2, 0), 8'hEE, 0);     // other tile
      check("R8", "err after wrong tile", 64'(err_flag), 1);
      check("R8", "no task wrong tile", 64'(task_valid), 0);
      send_arg(cont(1, 1, 0), 8'hEE, 0);     // idx1 not in use
      check("R8", "no task dead entry", 64'(task_valid), 0);
      send_arg(cont(1, 2, 3), 8'hEE, 0);     // slot 3 out of range
      check("R8", "no task bad slot", 64'(task_valid), 0);
      send_arg(cont(1, 2, 1), 8'h66, 1);
      check("R8", "counter untouched by drops", 64'(task_valid), 0);
      send_arg(cont(1, 2, 0), 8'h77, 2);
      check("R8", "entry completes on 2nd good arg", 64'(task_valid), 1);
      check("R8", "slots untouched by drops", 64'(task_args[15:0]), 64'h6677);
      check("R5", "idx2 type", 64'(task_type), 6);
      check("R5", "idx2 dest", 64'(task_dest), 2);
      send_arg(cont(1, 3, 2), 8'h99, 3);
      check("R5", "idx3 slot2", 64'(task_args[23:16]), 64'h99);
      check("R5", "idx3 type", 64'(task_type), 7);
      check("R8", "err still set", 64'(err_flag), 1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      t_reset();
      t_single();
      t_order();
      t_full();
      t_stall();
      t_errors();
      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule